// File: doc/BRIEF.md
# Out-of-Order Floating-Point Issue Core with Tag Renaming

This block accepts one decoded arithmetic operation per cycle and lets it run out of order. Each operation goes into a waiting slot that belongs to the class of unit it needs: an add/subtract unit or a multiply unit. When it enters its slot, each source register that still waits for an in-flight producer is replaced by the tag of the slot that will produce it. Operands that are already available are copied into the slot, so a later write to that register cannot change them. A slot begins execution when both of its operands are present and its unit is idle. Results leave on a single shared broadcast bus that carries a tag and a value. Every slot waiting on that tag takes the value in the same cycle. A register takes the value only if the tag it holds still names the broadcasting slot, so when several writes to one register are in flight, the last one issued is the one that lands.

The datapath is modular 16-bit integer arithmetic and stands in for the floating-point units. There are four architectural registers. There are five slots in all, each with a tag: three for the adder (tags 1 to 3) and two for the multiplier (tags 4 and 5). Tag 0 means "value present". A read port shows the value and pending tag of any register.

Top module: `fpr_core`

## Requirements
- R1: After reset, register k (k = 0..3) holds k+1 with pending tag 0, the broadcast bus is idle and `iss_ready` is high.
- R2: Opcodes: 2'b00 gives src1+src2, 2'b01 gives src1-src2, and 2'b10 or 2'b11 give src1*src2. All results are modulo 2^16. Opcodes 00 and 01 use the adder slots and opcodes 1x use the multiplier slots.
- R3: An accepted operation takes the lowest-numbered free slot of its class. Its tag is 1+index for adder slots and 4+index for multiplier slots. Only tags 1..5 appear on the bus.
- R4: `iss_ready` is low exactly when every slot of the class selected by `iss_op` is occupied. While it is low, the operation is not taken, and operations are accepted strictly in the order presented.
- R5: On acceptance, the destination's pending tag becomes the new slot's tag from the next cycle on. A source whose register has a nonzero pending tag records that tag instead of a value. Sources are looked up before the destination is renamed.
- R6: If a source's pending tag is on the bus in the very cycle of issue, the slot takes the bus value and does not record the tag.
- R7: Every occupied slot waiting on the broadcast tag, in either operand, takes the value on the same clock edge.
- R8: A slot whose operands are both present at the start of cycle t may start in cycle t when its unit is idle. Among such slots, the lowest-numbered one that has not started goes first. Its result is offered to the bus 2 cycles (adder) or 4 cycles (multiplier) after the start cycle. A unit runs one operation at a time and is idle again from the cycle after its broadcast.
- R9: When both units offer a result in the same cycle, the multiplier drives the bus and the adder holds its result until a later cycle.
- R10: A broadcast writes a register, and clears its pending tag, only if that register's pending tag equals the broadcast tag. A register renamed to a newer slot keeps its tag and value.
- R11: A slot is released on the edge that ends its broadcast cycle and can be allocated from the next cycle on.
- R12: An operand value copied into a slot is not changed by later register writes. An operation whose source register is overwritten by a later-issued operation still uses the value it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation is presented for issue |
| iss_op | input | 2 | Operation code (see R2) |
| iss_dst | input | 2 | Destination register |
| iss_src1 | input | 2 | First source register |
| iss_src2 | input | 2 | Second source register |
| iss_ready | output | 1 | A slot of the needed class is free; issue happens when valid and ready |
| bcast_valid | output | 1 | Broadcast bus carries a result this cycle |
| bcast_tag | output | 3 | Tag of the producing slot |
| bcast_value | output | 16 | Result value |
| rd_addr | input | 2 | Register selected for observation |
| rd_value | output | 16 | Current value of the selected register |
| rd_tag | output | 3 | Pending tag of the selected register, 0 if none |

## Verification
The bench is aimed at these cases:
- **Issue in the broadcast cycle.** An operation issues in the same cycle that its producer broadcasts. A design that records the stale tag would wait forever and the bus would fall silent.
- **Two writes to one register.** Two operations to the same destination are in flight at once. A design that writes on any tag match, or on a mismatch, would leave the older result in the register.
- **Both units finish together.** The adder and the multiplier finish in the same cycle. A design with the wrong priority, or one that drops the losing result, shows the wrong tag on the bus or never broadcasts that result.
- **Full slots.** Full slot groups stall issue, and the slot freed on one edge is refilled on the next. A design that frees slots early, or reuses a live tag, broadcasts values that do not match the reference.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 4;
    localparam int REG_W    = $clog2(NUM_REGS);
    localparam int N_ADD    = 3;
    localparam int N_MUL    = 2;
    localparam int N_TAGS   = N_ADD + N_MUL;
    localparam int TAG_W    = $clog2(N_TAGS + 1);
    localparam int ADD_LAT  = 2;
    localparam int MUL_LAT  = 4;
    localparam int OP_W     = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;

    // one waiting slot: occupied, started, subtract select, operands and their tags
    typedef struct packed {
        logic  busy;
        logic  run;
        logic  sub;
        word_t vj;
        word_t vk;
        tag_t  qj;
        tag_t  qk;
    } slot_t;

    function automatic word_t fu_calc(logic is_mul, logic sub, word_t a, word_t b);
        if (is_mul)   return a * b;
        else if (sub) return a - b;
        else          return a + b;
    endfunction
endpackage

// File: rtl/fpr_slot_bank.sv
module fpr_slot_bank
    import fpr_pkg::*;
#(
    parameter int N        = 3,
    parameter int TAG_BASE = 1,
    parameter int LAT      = 2,
    parameter bit IS_MUL   = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  alloc_en,
    input  logic  alloc_sub,
    input  word_t alloc_vj,
    input  tag_t  alloc_qj,
    input  word_t alloc_vk,
    input  tag_t  alloc_qk,
    input  logic  bus_valid,
    input  tag_t  bus_tag,
    input  word_t bus_value,
    input  logic  grant,
    output logic  has_free,
    output tag_t  free_tag,
    output logic  req,
    output tag_t  req_tag,
    output word_t req_value
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        slot_t [N-1:0]   rs;
        logic            ubusy;
        logic [CW-1:0]   ucnt;
        word_t           uval;
        tag_t            utag;
    } bank_t;

    bank_t bank_q, bank_d;

    always_comb begin : p_next
        int   fidx;
        logic started;
        bank_d   = bank_q;
        fidx     = 0;
        started  = 1'b0;
        has_free = 1'b0;
        free_tag = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!bank_q.rs[i].busy) begin
                has_free = 1'b1;
                free_tag = tag_t'(TAG_BASE + i);
                fidx     = i;
            end
        end

        req       = bank_q.ubusy && (bank_q.ucnt == '0);
        req_tag   = bank_q.utag;
        req_value = bank_q.uval;

        // unit: start a ready slot, count down, or release on grant
        if (!bank_q.ubusy) begin
            for (int i = 0; i < N; i++) begin
                if (!started && bank_q.rs[i].busy && !bank_q.rs[i].run &&
                    bank_q.rs[i].qj == '0 && bank_q.rs[i].qk == '0) begin
                    started           = 1'b1;
                    bank_d.rs[i].run  = 1'b1;
                    bank_d.ubusy      = 1'b1;
                    bank_d.ucnt       = CW'(LAT - 1);
                    bank_d.uval       = fu_calc(IS_MUL, bank_q.rs[i].sub,
                                                bank_q.rs[i].vj, bank_q.rs[i].vk);
                    bank_d.utag       = tag_t'(TAG_BASE + i);
                end
            end
        end else if (bank_q.ucnt != '0) begin
            bank_d.ucnt = bank_q.ucnt - 1'b1;
        end else if (grant) begin
            bank_d.ubusy = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (tag_t'(TAG_BASE + i) == bank_q.utag) begin
                    bank_d.rs[i].busy = 1'b0;
                    bank_d.rs[i].run  = 1'b0;
                end
            end
        end

        // every waiting slot snoops the bus at once
        for (int i = 0; i < N; i++) begin
            if (bus_valid && bank_q.rs[i].busy) begin
                if (bank_q.rs[i].qj == bus_tag) begin
                    bank_d.rs[i].vj = bus_value;
                    bank_d.rs[i].qj = '0;
                end
                if (bank_q.rs[i].qk == bus_tag) begin
                    bank_d.rs[i].vk = bus_value;
                    bank_d.rs[i].qk = '0;
                end
            end
        end

        if (alloc_en && has_free) begin
            bank_d.rs[fidx] = '{busy: 1'b1, run: 1'b0, sub: alloc_sub,
                                vj: alloc_vj, vk: alloc_vk,
                                qj: alloc_qj, qk: alloc_qk};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end
endmodule

// File: rtl/fpr_regstat.sv
module fpr_regstat
    import fpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src1,
    input  logic [REG_W-1:0] src2,
    input  logic [REG_W-1:0] dst,
    input  logic             ren_en,
    input  tag_t             ren_tag,
    input  logic             bus_valid,
    input  tag_t             bus_tag,
    input  word_t            bus_value,
    input  logic [REG_W-1:0] rd_addr,
    output word_t            op1_v,
    output tag_t             op1_q,
    output word_t            op2_v,
    output tag_t             op2_q,
    output word_t            rd_value,
    output tag_t             rd_tag
);
    typedef struct packed {
        word_t [NUM_REGS-1:0] val;
        tag_t  [NUM_REGS-1:0] tag;
    } rf_t;

    rf_t rf_q, rf_d;

    always_comb begin
        rf_d = rf_q;

        // source lookup with same-cycle bus forwarding
        op1_v = rf_q.val[src1];
        op1_q = rf_q.tag[src1];
        if (op1_q != '0 && bus_valid && bus_tag == op1_q) begin
            op1_v = bus_value;
            op1_q = '0;
        end
        op2_v = rf_q.val[src2];
        op2_q = rf_q.tag[src2];
        if (op2_q != '0 && bus_valid && bus_tag == op2_q) begin
            op2_v = bus_value;
            op2_q = '0;
        end

        for (int r = 0; r < NUM_REGS; r++) begin
            if (bus_valid && rf_q.tag[r] != '0 && rf_q.tag[r] == bus_tag) begin
                rf_d.val[r] = bus_value;
                rf_d.tag[r] = '0;
            end
        end
        if (ren_en) rf_d.tag[dst] = ren_tag;

        rd_value = rf_q.val[rd_addr];
        rd_tag   = rf_q.tag[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                rf_q.val[r] <= word_t'(r + 1);
                rf_q.tag[r] <= '0;
            end
        end else begin
            rf_q <= rf_d;
        end
    end
endmodule

// File: rtl/fpr_core.sv
module fpr_core
    import fpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [REG_W-1:0]  iss_src1,
    input  logic [REG_W-1:0]  iss_src2,
    output logic              iss_ready,
    output logic              bcast_valid,
    output logic [TAG_W-1:0]  bcast_tag,
    output logic [DATA_W-1:0] bcast_value,
    input  logic [REG_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_value,
    output logic [TAG_W-1:0]  rd_tag
);
    logic  use_mul, fire;
    logic  a_free, m_free, a_req, m_req;
    tag_t  a_ftag, m_ftag, a_rtag, m_rtag, op1_q, op2_q;
    word_t a_rval, m_rval, op1_v, op2_v;

    assign use_mul   = iss_op[OP_W-1];
    assign iss_ready = use_mul ? m_free : a_free;
    assign fire      = iss_valid && iss_ready;

    // multiplier owns the bus when both offer a result
    assign bcast_valid = a_req || m_req;
    assign bcast_tag   = m_req ? m_rtag : (a_req ? a_rtag : '0);
    assign bcast_value = m_req ? m_rval : a_rval;

    fpr_regstat u_regs (
        .clk(clk), .rst_n(rst_n),
        .src1(iss_src1), .src2(iss_src2), .dst(iss_dst),
        .ren_en(fire), .ren_tag(use_mul ? m_ftag : a_ftag),
        .bus_valid(bcast_valid), .bus_tag(bcast_tag), .bus_value(bcast_value),
        .rd_addr(rd_addr),
        .op1_v(op1_v), .op1_q(op1_q), .op2_v(op2_v), .op2_q(op2_q),
        .rd_value(rd_value), .rd_tag(rd_tag)
    );

    fpr_slot_bank #(.N(N_ADD), .TAG_BASE(1), .LAT(ADD_LAT), .IS_MUL(1'b0)) u_add (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(fire && !use_mul), .alloc_sub(iss_op[0]),
        .alloc_vj(op1_v), .alloc_qj(op1_q), .alloc_vk(op2_v), .alloc_qk(op2_q),
        .bus_valid(bcast_valid), .bus_tag(bcast_tag), .bus_value(bcast_value),
        .grant(a_req && !m_req),
        .has_free(a_free), .free_tag(a_ftag),
        .req(a_req), .req_tag(a_rtag), .req_value(a_rval)
    );

    fpr_slot_bank #(.N(N_MUL), .TAG_BASE(1 + N_ADD), .LAT(MUL_LAT), .IS_MUL(1'b1)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(fire && use_mul), .alloc_sub(iss_op[0]),
        .alloc_vj(op1_v), .alloc_qj(op1_q), .alloc_vk(op2_v), .alloc_qk(op2_q),
        .bus_valid(bcast_valid), .bus_tag(bcast_tag), .bus_value(bcast_value),
        .grant(m_req),
        .has_free(m_free), .free_tag(m_ftag),
        .req(m_req), .req_tag(m_rtag), .req_value(m_rval)
    );
endmodule

// File: rtl/fpr_core_chk.sv
module fpr_core_chk
    import fpr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [REG_W-1:0]  iss_dst,
    input logic              bcast_valid,
    input logic [TAG_W-1:0]  bcast_tag,
    input logic [DATA_W-1:0] bcast_value,
    input logic [REG_W-1:0]  rd_addr,
    input logic [DATA_W-1:0] rd_value,
    input logic [TAG_W-1:0]  rd_tag
);
    logic renames_rd;
    assign renames_rd = iss_valid && iss_ready && (iss_dst == rd_addr);

    AST_BUS_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |-> (bcast_tag != '0 && bcast_tag <= TAG_W'(N_TAGS))); // R3

    AST_NO_BACK_TO_BACK_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |=> !(bcast_valid && bcast_tag == $past(bcast_tag))); // R11

    AST_MATCH_WRITES_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_valid && rd_tag != '0 && rd_tag == bcast_tag && !renames_rd) |=>
        (rd_addr != $past(rd_addr)) || (rd_tag == '0 && rd_value == $past(bcast_value))); // R10

    AST_STALE_TAG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_valid && rd_tag != '0 && rd_tag != bcast_tag && !renames_rd) |=>
        (rd_addr != $past(rd_addr)) ||
        (rd_tag == $past(rd_tag) && rd_value == $past(rd_value))); // R10

    AST_RENAME_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        renames_rd |=> (rd_addr != $past(rd_addr)) || (rd_tag != '0)); // R5
endmodule

bind fpr_core fpr_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_dst(iss_dst), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
    .bcast_value(bcast_value), .rd_addr(rd_addr), .rd_value(rd_value), .rd_tag(rd_tag)
);

// File: tb/fpr_core_test.sv
module fpr_core_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        iss_valid;
    logic [1:0]  iss_op, iss_dst, iss_src1, iss_src2, rd_addr;
    logic        iss_ready, bcast_valid;
    logic [2:0]  bcast_tag, rd_tag;
    logic [15:0] bcast_value, rd_value;

    always #5 clk = ~clk;

    fpr_core uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_ready(iss_ready), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
        .bcast_value(bcast_value), .rd_addr(rd_addr), .rd_value(rd_value), .rd_tag(rd_tag)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // behavioural reference state
    logic [15:0] rv [4];
    int          rt [4];
    bit          sb [6], sr [6], ssub [6];
    logic [15:0] svj [6], svk [6];
    int          sqj [6], sqk [6];
    bit          ub [2];
    int          uc [2], ut [2];
    logic [15:0] uv [2];

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare outputs for this cycle, then advance the reference one edge
    task automatic step(output bit acc);
        bit reqA, reqM, bv, rdy, grant, started;
        int bt, af, mf, nt, q1, q2, lo, hi, lat;
        logic [15:0] bval, v1, v2;
        reqA = ub[0] && uc[0] == 0;
        reqM = ub[1] && uc[1] == 0;
        bv   = reqA || reqM;
        bt   = reqM ? ut[1] : (reqA ? ut[0] : 0);      // R9 multiplier first
        bval = reqM ? uv[1] : uv[0];
        af = 0; mf = 0;
        for (int t = 3; t >= 1; t--) if (!sb[t]) af = t; // R3 lowest free
        for (int t = 5; t >= 4; t--) if (!sb[t]) mf = t;
        rdy = iss_op[1] ? (mf != 0) : (af != 0);

        chk("R4", "iss_ready", iss_ready, rdy);
        chk("R9", "bcast_valid", bcast_valid, bv);
        if (bv) begin
            chk("R3", "bcast_tag", bcast_tag, bt);
            chk("R2", "bcast_value", bcast_value, bval);
        end
        chk("R10", "rd_value", rd_value, rv[rd_addr]);
        chk("R5", "rd_tag", rd_tag, rt[rd_addr]);

        acc = iss_valid && rdy;
        nt  = iss_op[1] ? mf : af;
        // R5 lookup before rename, R6 forward from the bus at issue
        q1 = rt[iss_src1]; v1 = rv[iss_src1];
        if (q1 != 0 && bv && q1 == bt) begin v1 = bval; q1 = 0; end
        q2 = rt[iss_src2]; v2 = rv[iss_src2];
        if (q2 != 0 && bv && q2 == bt) begin v2 = bval; q2 = 0; end

        for (int u = 0; u < 2; u++) begin
            lo = u ? 4 : 1; hi = u ? 5 : 3; lat = u ? 4 : 2;
            grant = u ? reqM : (reqA && !reqM);
            started = 1'b0;
            if (!ub[u]) begin
                for (int t = lo; t <= hi; t++) begin
                    if (!started && sb[t] && !sr[t] && sqj[t] == 0 && sqk[t] == 0) begin
                        started = 1'b1;                 // R8 start when both present
                        sr[t] = 1'b1; ub[u] = 1'b1; uc[u] = lat - 1; ut[u] = t;
                        if (u == 1)       uv[u] = svj[t] * svk[t];
                        else if (ssub[t]) uv[u] = svj[t] - svk[t];
                        else              uv[u] = svj[t] + svk[t];
                    end
                end
            end else if (uc[u] > 0) begin
                uc[u]--;
            end else if (grant) begin
                ub[u] = 1'b0; sb[ut[u]] = 1'b0; sr[ut[u]] = 1'b0; // R11 release
            end
        end

        if (bv) begin
            for (int t = 1; t <= 5; t++) begin
                if (sb[t]) begin                          // R7 all capture, R12 kept copy
                    if (sqj[t] == bt) begin svj[t] = bval; sqj[t] = 0; end
                    if (sqk[t] == bt) begin svk[t] = bval; sqk[t] = 0; end
                end
            end
            for (int r = 0; r < 4; r++)
                if (rt[r] != 0 && rt[r] == bt) begin rv[r] = bval; rt[r] = 0; end // R10
        end

        if (acc) begin
            sb[nt] = 1'b1; sr[nt] = 1'b0; ssub[nt] = iss_op[0];
            svj[nt] = v1; sqj[nt] = q1; svk[nt] = v2; sqk[nt] = q2;
            rt[iss_dst] = nt;
        end
    endtask

    function automatic logic [7:0] directed(int i);
        case (i)
            0:  return {2'b10, 2'd0, 2'd1, 2'd2};  // mul r0 = r1*r2
            1:  return {2'b00, 2'd3, 2'd0, 2'd1};  // RAW on r0
            2:  return {2'b01, 2'd1, 2'd2, 2'd2};  // WAR on r1
            3:  return {2'b11, 2'd3, 2'd3, 2'd3};  // WAW on r3
            4:  return {2'b00, 2'd2, 2'd0, 2'd0};
            5:  return {2'b00, 2'd0, 2'd1, 2'd2};
            6:  return {2'b00, 2'd1, 2'd1, 2'd1};  // adder group fills
            7:  return {2'b00, 2'd2, 2'd2, 2'd3};
            8:  return {2'b10, 2'd0, 2'd0, 2'd1};
            9:  return {2'b10, 2'd1, 2'd0, 2'd3};
            10: return {2'b10, 2'd2, 2'd2, 2'd2};  // multiplier group full
            default: return {2'b01, 2'd3, 2'd0, 2'd1};
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        bit pend, acc;
        int di;
        logic [7:0] enc;
        rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0; iss_dst = '0;
        iss_src1 = '0; iss_src2 = '0; rd_addr = '0;
        for (int r = 0; r < 4; r++) begin rv[r] = 16'(r + 1); rt[r] = 0; end
        for (int t = 0; t < 6; t++) begin
            sb[t] = 0; sr[t] = 0; ssub[t] = 0; svj[t] = 0; svk[t] = 0; sqj[t] = 0; sqk[t] = 0;
        end
        for (int u = 0; u < 2; u++) begin ub[u] = 0; uc[u] = 0; ut[u] = 0; uv[u] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int k = 0; k < 4; k++) begin                // R1 reset state
            @(negedge clk) rd_addr = 2'(k);
            #1;
            chk("R1", "reset value", rd_value, k + 1);
            chk("R1", "reset tag", rd_tag, 0);
            chk("R1", "reset ready", iss_ready, 1);
            chk("R1", "reset bus idle", bcast_valid, 0);
        end

        pend = 1'b0; di = 0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (!pend) begin
                if (di < 12) begin
                    enc = directed(di); di++; pend = 1'b1;
                end else if (cyc < 2950) begin
                    enc = 8'($urandom); pend = ($urandom % 4) != 0;
                end
                {iss_op, iss_dst, iss_src1, iss_src2} = enc;
            end
            iss_valid = pend;                            // R4 hold until accepted
            rd_addr   = 2'($urandom);
            #1;
            step(acc);
            if (acc) pend = 1'b0;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule